// File: doc/BRIEF.md
# Protected Timekeeper Register Access Controller

This block sits between a serial front end, which has already assembled bytes from the wire, and the storage of a timekeeping device. The front end raises a select line for the length of a transaction. It presents one command byte, and then either presents data bytes to be written or asks for the next byte to be read. The controller holds two address spaces. The clock space has seven time registers (indices 0 to 6), a control register at index 7 and a charger-configuration register at index 8. The RAM space is a scratch store of `RAM_DEPTH` bytes, 31 by default. Counting the time and shifting bits on the wire are handled by other blocks.

The controller enforces a write-protect flag held in bit 7 of the control register. A burst write to the clock space is collected in a shadow buffer and lands in the registers in one cycle, and only once all eight bytes have arrived. A RAM burst stores each byte as soon as it arrives. The controller also decodes the charger-configuration register into an enable, a diode count and a resistor choice. The charger is enabled only by a 4-bit key combined with legal select codes.

Top module: `rtc_regfile_guard`

## Requirements
- R1: After reset, `wp_o` is 1, all time registers and all RAM bytes are 0x00, and the charger-configuration register is 0x00, so the charger is disabled.
- R2: The command byte is decoded as follows. Bit 7 is a write enable: a data byte is ignored when this bit is 0. Bit 6 selects the space (0 = clock, 1 = RAM). Bits 5:1 give the address. Bit 0 set means read. Address 31 selects burst mode. `rd_data_o` is 0x00 unless a read transaction is active.
- R3: The control register reads as `{wp, 7'b0}`. A byte write to it is accepted even while write protect is set, and only data bit 7 is kept.
- R4: While write protect is 1, byte writes to the time registers, to the charger-configuration register and to RAM change nothing.
- R5: In byte mode, only the first data byte of a transaction is stored and later ones are ignored. A byte-mode read shows the addressed byte and keeps showing it however often the read is advanced.
- R6: A clock burst write changes none of the eight clock registers (time 0 to 6 and control) until the eighth data byte arrives. Then all eight change in the same cycle. A burst that ends early changes nothing.
- R7: If write protect is 1 when a clock burst write begins, none of the eight registers changes, including the control register.
- R8: A RAM burst write stores data byte k at RAM address k as it arrives, for k from 0 to `RAM_DEPTH`-1. The bytes already stored remain if the burst ends early, and bytes beyond the last address are ignored.
- R9: Clock addresses 9 to 30 and RAM addresses at or above `RAM_DEPTH` read as 0x00. Writes to them change no register.
- R10: A burst read starts at address 0 and advances by one on each `rd_adv_i`. It wraps from address 7 (clock space) or from address `RAM_DEPTH`-1 (RAM space) back to 0.
- R11: The charger is enabled only when configuration bits 7:4 are 1010, bits 3:2 are 01 (one diode) or 10 (two diodes), and bits 1:0 are not 00. When enabled, `chg_res_o` equals bits 1:0 and `chg_two_diode_o` is 1 for code 10. When disabled, both outputs are 0.
- R12: A clock burst write never alters the charger-configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Transaction select; low ends a transaction |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_i | input | 8 | Command byte |
| wr_valid_i | input | 1 | Data byte strobe for writes |
| wr_data_i | input | 8 | Data byte to write |
| rd_adv_i | input | 1 | Advance to the next read byte |
| rd_data_o | output | 8 | Byte currently presented for reading |
| time_o | output | 8*TIME_REGS | Time registers, register i in bits 8i+7:8i |
| wp_o | output | 1 | Write-protect flag |
| chg_en_o | output | 1 | Charger enable |
| chg_two_diode_o | output | 1 | Two diodes selected |
| chg_res_o | output | 2 | Resistor choice, 0 when disabled |

## Verification
The hardest state to reach is a clock burst that has staged seven bytes but has not yet been committed. The bench builds this state by holding select high and sending exactly seven bytes. It then checks that the time registers have not moved, and only then sends the eighth byte. A separate burst is ended after five bytes to show that the shadow contents are discarded. Protection at the start of a burst is exercised in its own test: protect is set first, and then a full burst is sent whose final byte would clear it.

// File: rtl/rac_pkg.sv
package rac_pkg;
   localparam int CMD_ADDR_W = 5;
   localparam logic [CMD_ADDR_W-1:0] BURST_ADDR = 5'd31;

   typedef enum logic {
      SPACE_CLK = 1'b0,
      SPACE_RAM = 1'b1
   } space_e;

   typedef struct packed {
      logic                  wr_en;
      space_e                space;
      logic [CMD_ADDR_W-1:0] addr;
      logic                  rd;
   } cmd_t;
endpackage

// File: rtl/rac_xfer_seq.sv
module rac_xfer_seq
   import rac_pkg::*;
#(
   parameter int RAM_DEPTH = 31,
   parameter int CLK_BURST = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_i,
   input  logic                  cmd_valid_i,
   input  cmd_t                  cmd_i,
   input  logic                  wr_valid_i,
   input  logic                  rd_adv_i,
   input  logic                  wp_i,
   output logic                  active_o,
   output logic                  rd_mode_o,
   output space_e                space_o,
   output logic [CMD_ADDR_W-1:0] rd_addr_o,
   output logic                  byte_we_o,
   output logic [CMD_ADDR_W-1:0] byte_addr_o,
   output logic                  ram_bwe_o,
   output logic [CMD_ADDR_W-1:0] bidx_o,
   output logic                  stage_we_o,
   output logic                  commit_o
);
   localparam int WMAX  = (RAM_DEPTH > CLK_BURST) ? RAM_DEPTH : CLK_BURST;
   localparam int CNT_W = $clog2(WMAX + 1);
   localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(WMAX);
   localparam logic [CNT_W-1:0] RAM_LIM   = CNT_W'(RAM_DEPTH);
   localparam logic [CNT_W-1:0] CLK_LIM   = CNT_W'(CLK_BURST);
   localparam logic [CNT_W-1:0] CLK_FINAL = CNT_W'(CLK_BURST - 1);
   localparam logic [CMD_ADDR_W-1:0] RAM_LAST = CMD_ADDR_W'(RAM_DEPTH - 1);
   localparam logic [CMD_ADDR_W-1:0] CLK_LAST = CMD_ADDR_W'(CLK_BURST - 1);
   localparam logic [CMD_ADDR_W-1:0] CTRL_IDX = CMD_ADDR_W'(CLK_BURST - 1);

   logic                  active_q;
   cmd_t                  cmd_q;
   logic                  wp_lat_q;
   logic [CMD_ADDR_W-1:0] ptr_q;
   logic [CNT_W-1:0]      wcnt_q;

   logic is_burst, wr_ok, rd_ok, ctrl_target;
   logic [CMD_ADDR_W-1:0] wrap_last;

   assign is_burst    = (cmd_q.addr == BURST_ADDR);
   assign wr_ok       = active_q && sel_i && wr_valid_i && cmd_q.wr_en && !cmd_q.rd;
   assign rd_ok       = active_q && sel_i && rd_adv_i && cmd_q.rd;
   assign ctrl_target = (cmd_q.space == SPACE_CLK) && (cmd_q.addr == CTRL_IDX);
   assign wrap_last   = (cmd_q.space == SPACE_RAM) ? RAM_LAST : CLK_LAST;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cmd_q    <= '0;
         wp_lat_q <= 1'b1;
         ptr_q    <= '0;
         wcnt_q   <= '0;
      end else if (!sel_i) begin
         active_q <= 1'b0;
      end else if (cmd_valid_i) begin
         active_q <= 1'b1;
         cmd_q    <= cmd_i;
         wp_lat_q <= wp_i;
         ptr_q    <= (cmd_i.addr == BURST_ADDR) ? '0 : cmd_i.addr;
         wcnt_q   <= '0;
      end else if (active_q) begin
         if (wr_ok && wcnt_q != CNT_MAX)
            wcnt_q <= wcnt_q + 1'b1;
         if (rd_ok && is_burst)
            ptr_q <= (ptr_q == wrap_last) ? '0 : ptr_q + 1'b1;
      end
   end

   always_comb begin
      byte_we_o  = wr_ok && !is_burst && (wcnt_q == '0) && (!wp_lat_q || ctrl_target);
      ram_bwe_o  = wr_ok && is_burst && (cmd_q.space == SPACE_RAM) && !wp_lat_q
                   && (wcnt_q < RAM_LIM);
      stage_we_o = wr_ok && is_burst && (cmd_q.space == SPACE_CLK) && (wcnt_q < CLK_LIM);
      commit_o   = stage_we_o && (wcnt_q == CLK_FINAL) && !wp_lat_q;
   end

   assign active_o    = active_q;
   assign rd_mode_o   = cmd_q.rd;
   assign space_o     = cmd_q.space;
   assign rd_addr_o   = ptr_q;
   assign byte_addr_o = cmd_q.addr;
   assign bidx_o      = CMD_ADDR_W'(wcnt_q);
endmodule

// File: rtl/rac_clk_bank.sv
module rac_clk_bank
   import rac_pkg::*;
#(
   parameter int           TIME_REGS   = 7,
   parameter int           CLK_BURST   = 8,
   parameter logic [7:0]   TRICKLE_RST = 8'h00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_we_i,
   input  logic [CMD_ADDR_W-1:0]   byte_addr_i,
   input  logic [7:0]              data_i,
   input  logic                    stage_we_i,
   input  logic [CMD_ADDR_W-1:0]   stage_idx_i,
   input  logic                    commit_i,
   input  logic [CMD_ADDR_W-1:0]   rd_addr_i,
   output logic [8*TIME_REGS-1:0]  time_o,
   output logic                    wp_o,
   output logic [7:0]              trickle_o,
   output logic [7:0]              rd_data_o
);
   localparam int SHADOW_N = CLK_BURST - 1;
   localparam logic [CMD_ADDR_W-1:0] CTRL_IDX = CMD_ADDR_W'(TIME_REGS);
   localparam logic [CMD_ADDR_W-1:0] TRK_IDX  = CMD_ADDR_W'(TIME_REGS + 1);

   logic [7:0] shadow_q [SHADOW_N];
   logic [7:0] time_q   [TIME_REGS];
   logic       wp_q;
   logic [7:0] trk_q;

   for (genvar s = 0; s < SHADOW_N; s++) begin : g_shadow
      always_ff @(posedge clk) begin
         if (!rst_n)
            shadow_q[s] <= '0;
         else if (stage_we_i && stage_idx_i == CMD_ADDR_W'(s))
            shadow_q[s] <= data_i;
      end
   end

   for (genvar t = 0; t < TIME_REGS; t++) begin : g_time
      always_ff @(posedge clk) begin
         if (!rst_n)
            time_q[t] <= '0;
         else if (commit_i)
            time_q[t] <= shadow_q[t];
         else if (byte_we_i && byte_addr_i == CMD_ADDR_W'(t))
            time_q[t] <= data_i;
      end
      assign time_o[8*t +: 8] = time_q[t];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= 1'b1;
         trk_q <= TRICKLE_RST;
      end else begin
         if (commit_i || (byte_we_i && byte_addr_i == CTRL_IDX))
            wp_q <= data_i[7];
         if (byte_we_i && byte_addr_i == TRK_IDX)
            trk_q <= data_i;
      end
   end

   always_comb begin
      rd_data_o = 8'h00;
      for (int t = 0; t < TIME_REGS; t++)
         if (rd_addr_i == CMD_ADDR_W'(t))
            rd_data_o = time_q[t];
      if (rd_addr_i == CTRL_IDX)
         rd_data_o = {wp_q, 7'b0};
      if (rd_addr_i == TRK_IDX)
         rd_data_o = trk_q;
   end

   assign wp_o      = wp_q;
   assign trickle_o = trk_q;
endmodule

// File: rtl/rac_ram_bank.sv
module rac_ram_bank
   import rac_pkg::*;
#(
   parameter int RAM_DEPTH    = 31,
   parameter bit CLEAR_ON_RST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we_i,
   input  logic [CMD_ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]            data_i,
   input  logic [CMD_ADDR_W-1:0] rd_addr_i,
   output logic [7:0]            rd_data_o
);
   logic [7:0] mem_q [RAM_DEPTH];

   for (genvar a = 0; a < RAM_DEPTH; a++) begin : g_cell
      logic hit;
      assign hit = we_i && (wr_addr_i == CMD_ADDR_W'(a));
      if (CLEAR_ON_RST) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)   mem_q[a] <= '0;
            else if (hit) mem_q[a] <= data_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) mem_q[a] <= data_i;
         end
      end
   end

   always_comb begin
      rd_data_o = 8'h00;
      for (int a = 0; a < RAM_DEPTH; a++)
         if (rd_addr_i == CMD_ADDR_W'(a))
            rd_data_o = mem_q[a];
   end
endmodule

// File: rtl/rac_trickle_dec.sv
module rac_trickle_dec #(
   parameter logic [3:0] KEY = 4'b1010
) (
   input  logic [7:0] cfg_i,
   output logic       en_o,
   output logic       two_diode_o,
   output logic [1:0] res_o
);
   logic key_ok, diode_ok, res_ok;

   assign key_ok      = (cfg_i[7:4] == KEY);
   assign diode_ok    = (cfg_i[3:2] == 2'b01) || (cfg_i[3:2] == 2'b10);
   assign res_ok      = (cfg_i[1:0] != 2'b00);
   assign en_o        = key_ok && diode_ok && res_ok;
   assign two_diode_o = en_o && cfg_i[3];
   assign res_o       = en_o ? cfg_i[1:0] : 2'b00;
endmodule

// File: rtl/rtc_regfile_guard.sv
module rtc_regfile_guard
   import rac_pkg::*;
#(
   parameter int         TIME_REGS    = 7,
   parameter int         RAM_DEPTH    = 31,
   parameter logic [7:0] TRICKLE_RST  = 8'h00,
   parameter logic [3:0] TRICKLE_KEY  = 4'b1010,
   parameter bit         RAM_CLEAR    = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sel_i,
   input  logic                   cmd_valid_i,
   input  logic [7:0]             cmd_i,
   input  logic                   wr_valid_i,
   input  logic [7:0]             wr_data_i,
   input  logic                   rd_adv_i,
   output logic [7:0]             rd_data_o,
   output logic [8*TIME_REGS-1:0] time_o,
   output logic                   wp_o,
   output logic                   chg_en_o,
   output logic                   chg_two_diode_o,
   output logic [1:0]             chg_res_o
);
   localparam int CLK_BURST = TIME_REGS + 1;

   if (RAM_DEPTH < 1 || RAM_DEPTH > 31) begin : g_bad_depth
      $error("RAM_DEPTH must lie in 1..31");
   end
   if (TIME_REGS < 1 || TIME_REGS + 1 >= 31) begin : g_bad_time
      $error("TIME_REGS leaves no room for control and charger registers");
   end
   if (TRICKLE_RST[7:4] == TRICKLE_KEY) begin : g_bad_trk
      $error("TRICKLE_RST must leave the charger disabled");
   end

   logic                  active, rd_mode, byte_we, ram_bwe, stage_we, commit;
   space_e                space;
   logic [CMD_ADDR_W-1:0] rd_addr, byte_addr, bidx;
   logic [7:0]            clk_rd, ram_rd, trk;
   logic                  ram_we;
   logic [CMD_ADDR_W-1:0] ram_addr;

   rac_xfer_seq #(.RAM_DEPTH(RAM_DEPTH), .CLK_BURST(CLK_BURST)) u_seq (
      .clk, .rst_n, .sel_i, .cmd_valid_i,
      .cmd_i       (cmd_t'(cmd_i)),
      .wr_valid_i, .rd_adv_i,
      .wp_i        (wp_o),
      .active_o    (active),
      .rd_mode_o   (rd_mode),
      .space_o     (space),
      .rd_addr_o   (rd_addr),
      .byte_we_o   (byte_we),
      .byte_addr_o (byte_addr),
      .ram_bwe_o   (ram_bwe),
      .bidx_o      (bidx),
      .stage_we_o  (stage_we),
      .commit_o    (commit)
   );

   rac_clk_bank #(
      .TIME_REGS(TIME_REGS), .CLK_BURST(CLK_BURST), .TRICKLE_RST(TRICKLE_RST)
   ) u_clk (
      .clk, .rst_n,
      .byte_we_i   (byte_we && space == SPACE_CLK),
      .byte_addr_i (byte_addr),
      .data_i      (wr_data_i),
      .stage_we_i  (stage_we),
      .stage_idx_i (bidx),
      .commit_i    (commit),
      .rd_addr_i   (rd_addr),
      .time_o,
      .wp_o,
      .trickle_o   (trk),
      .rd_data_o   (clk_rd)
   );

   assign ram_we   = ram_bwe || (byte_we && space == SPACE_RAM);
   assign ram_addr = ram_bwe ? bidx : byte_addr;

   rac_ram_bank #(.RAM_DEPTH(RAM_DEPTH), .CLEAR_ON_RST(RAM_CLEAR)) u_ram (
      .clk, .rst_n,
      .we_i      (ram_we),
      .wr_addr_i (ram_addr),
      .data_i    (wr_data_i),
      .rd_addr_i (rd_addr),
      .rd_data_o (ram_rd)
   );

   rac_trickle_dec #(.KEY(TRICKLE_KEY)) u_trk (
      .cfg_i       (trk),
      .en_o        (chg_en_o),
      .two_diode_o (chg_two_diode_o),
      .res_o       (chg_res_o)
   );

   always_comb begin
      if (!(active && rd_mode))       rd_data_o = 8'h00;
      else if (space == SPACE_RAM)    rd_data_o = ram_rd;
      else                            rd_data_o = clk_rd;
   end
endmodule

// File: rtl/rtc_regfile_guard_chk.sv
module rtc_regfile_guard_chk #(
   parameter int TIME_REGS = 7
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sel_i,
   input logic                   wr_valid_i,
   input logic [7:0]             rd_data_o,
   input logic [8*TIME_REGS-1:0] time_o,
   input logic                   wp_o,
   input logic                   chg_en_o,
   input logic                   chg_two_diode_o,
   input logic [1:0]             chg_res_o
);
   AST_PROTECT_FREEZES_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wp_o) |-> $stable(time_o)); // R4

   AST_TIME_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_valid_i) |-> $stable(time_o)); // R6

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!sel_i) |-> rd_data_o == 8'h00); // R2

   AST_CHG_HAS_RESISTOR: assert property (@(posedge clk) disable iff (!rst_n)
      chg_en_o |-> chg_res_o != 2'b00); // R11

   AST_CHG_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_en_o |-> (chg_res_o == 2'b00 && !chg_two_diode_o)); // R11
endmodule

bind rtc_regfile_guard rtc_regfile_guard_chk #(.TIME_REGS(TIME_REGS)) u_chk (.*);

// File: tb/rtc_regfile_guard_test.sv
module rtc_regfile_guard_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_i = 1'b0, cmd_valid_i = 1'b0, wr_valid_i = 1'b0, rd_adv_i = 1'b0;
   logic [7:0] cmd_i = '0, wr_data_i = '0;
   logic [7:0] rd_data_o;
   logic [55:0] time_o;
   logic       wp_o, chg_en_o, chg_two_diode_o;
   logic [1:0] chg_res_o;

   int nvec = 0, nbad = 0;
   logic [7:0] v;

   always #10 clk = ~clk;

   rtc_regfile_guard uut (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic begin_x(input logic [7:0] c);
      @(negedge clk); sel_i = 1'b1; cmd_valid_i = 1'b1; cmd_i = c;
      @(negedge clk); cmd_valid_i = 1'b0;
   endtask
   task automatic end_x();
      @(negedge clk); sel_i = 1'b0;
      @(negedge clk);
   endtask
   task automatic put(input logic [7:0] d);
      wr_valid_i = 1'b1; wr_data_i = d;
      @(negedge clk); wr_valid_i = 1'b0;
   endtask
   task automatic adv();
      rd_adv_i = 1'b1;
      @(negedge clk); rd_adv_i = 1'b0;
   endtask
   task automatic wr_one(input logic [7:0] c, input logic [7:0] d);
      begin_x(c); put(d); end_x();
   endtask
   task automatic rd_one(input logic [7:0] c, output logic [7:0] d);
      begin_x(c); d = rd_data_o; end_x();
   endtask

   task automatic t_reset();
      chk("R1 wp after reset", wp_o, 1);
      chk("R1 time after reset", time_o, 0);
      chk("R1 charger off", chg_en_o, 0);
      rd_one(8'hC1, v); chk("R1 ram0 cleared", v, 8'h00);
      rd_one(8'h8F, v); chk("R3 control reads 80", v, 8'h80);
      chk("R2 idle read zero", rd_data_o, 8'h00);
   endtask

   task automatic t_protect();
      wr_one(8'hCA, 8'h11); rd_one(8'hCB, v); chk("R4 ram5 blocked", v, 8'h00);
      wr_one(8'h80, 8'h22); chk("R4 seconds blocked", time_o, 0);
      wr_one(8'h90, 8'hA5); chk("R4 charger blocked", chg_en_o, 0);
      rd_one(8'h91, v); chk("R4 charger reg blocked", v, 8'h00);
   endtask

   task automatic t_ctrl();
      wr_one(8'h8E, 8'h7F);
      chk("R3 wp cleared", wp_o, 0);
      rd_one(8'h8F, v); chk("R3 low bits zero", v, 8'h00);
   endtask

   task automatic t_byte();
      begin_x(8'hC6); put(8'h5A); put(8'h77); end_x();
      begin_x(8'hC7);
      chk("R5 ram3 first byte", rd_data_o, 8'h5A);
      adv(); chk("R5 byte read repeats", rd_data_o, 8'h5A);
      end_x();
      wr_one(8'h46, 8'h99); rd_one(8'hC7, v); chk("R2 bit7 clear ignored", v, 8'h5A);
      wr_one(8'h86, 8'h33);
      chk("R2 clock space write", time_o, 56'h00000033000000);
      rd_one(8'hC7, v); chk("R2 ram untouched by clock write", v, 8'h5A);
   endtask

   task automatic t_cburst();
      begin_x(8'hBE);
      for (int k = 0; k < 5; k++) put(8'h10 + 8'(k));
      end_x();
      chk("R6 aborted burst", time_o, 56'h00000033000000);
      begin_x(8'hBE);
      for (int k = 0; k < 7; k++) put(8'h10 + 8'(k));
      chk("R6 no commit before eighth", time_o, 56'h00000033000000);
      chk("R6 wp unchanged before eighth", wp_o, 0);
      put(8'h00);
      chk("R6 commit at eighth", time_o, 56'h16151413121110);
      chk("R6 control committed", wp_o, 0);
      end_x();
      rd_one(8'h91, v); chk("R12 charger untouched by burst", v, 8'h00);
   endtask

   task automatic t_cread();
      begin_x(8'hBF);
      for (int k = 0; k < 7; k++) begin
         chk("R10 clock burst read", rd_data_o, 8'h10 + 8'(k));
         adv();
      end
      chk("R10 control in burst", rd_data_o, 8'h00);
      adv(); chk("R10 clock wrap", rd_data_o, 8'h10);
      end_x();
   endtask

   task automatic t_ram();
      begin_x(8'hFE); put(8'hA0); put(8'hA1); put(8'hA2); end_x();
      rd_one(8'hC1, v); chk("R8 ram0 partial", v, 8'hA0);
      rd_one(8'hC3, v); chk("R8 ram1 partial", v, 8'hA1);
      rd_one(8'hC5, v); chk("R8 ram2 partial", v, 8'hA2);
      rd_one(8'hC7, v); chk("R8 ram3 kept", v, 8'h5A);
      begin_x(8'hFE);
      for (int k = 0; k < 33; k++) put(8'h40 + 8'(k));
      end_x();
      rd_one(8'hC1, v); chk("R8 ram0 no wrap", v, 8'h40);
      rd_one(8'hFD, v); chk("R8 ram30 last", v, 8'h5E);
      begin_x(8'hFF);
      chk("R10 ram burst start", rd_data_o, 8'h40);
      for (int k = 0; k < 30; k++) adv();
      chk("R10 ram burst end", rd_data_o, 8'h5E);
      adv(); chk("R10 ram wrap", rd_data_o, 8'h40);
      end_x();
   endtask

   task automatic t_empty();
      rd_one(8'h93, v); chk("R9 clock addr 9 zero", v, 8'h00);
      rd_one(8'h9D, v); chk("R9 clock addr 14 zero", v, 8'h00);
      wr_one(8'h94, 8'hFF);
      chk("R9 empty write time", time_o, 56'h16151413121110);
      rd_one(8'h91, v); chk("R9 empty write charger", v, 8'h00);
      chk("R9 empty write wp", wp_o, 0);
   endtask

   task automatic trk(input logic [7:0] c, input logic en, input logic two, input logic [1:0] r);
      wr_one(8'h90, c);
      chk($sformatf("R11 en for %h", c), chg_en_o, en);
      chk($sformatf("R11 diode for %h", c), chg_two_diode_o, two);
      chk($sformatf("R11 res for %h", c), chg_res_o, r);
   endtask

   task automatic t_trk();
      trk(8'hA5, 1, 0, 2'd1);
      trk(8'hA9, 1, 1, 2'd1);
      trk(8'hAB, 1, 1, 2'd3);
      trk(8'hA4, 0, 0, 2'd0);
      trk(8'hAD, 0, 0, 2'd0);
      trk(8'hA1, 0, 0, 2'd0);
      trk(8'hB5, 0, 0, 2'd0);
      rd_one(8'h91, v); chk("R11 readback", v, 8'hB5);
   endtask

   task automatic t_wp_burst();
      wr_one(8'h8E, 8'h80); chk("R3 wp set", wp_o, 1);
      begin_x(8'hBE);
      for (int k = 0; k < 7; k++) put(8'h99);
      put(8'h00);
      end_x();
      chk("R7 time unchanged", time_o, 56'h16151413121110);
      chk("R7 control unchanged", wp_o, 1);
      rd_one(8'h91, v); chk("R12 charger kept", v, 8'hB5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_protect();
      t_ctrl();
      t_byte();
      t_cburst();
      t_cread();
      t_ram();
      t_empty();
      t_trk();
      t_wp_burst();
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule